// File: doc/BRIEF.md
# SPI Serial Clock and Inter-Word Gap Timer

This block is the timing core of an SPI master. From one source clock it produces single-cycle strobes that tell the shift engine when to toggle the serial clock. It also inserts a fixed idle gap between consecutive words and raises a one-cycle strobe at the start of each word. It does not shift data, handle polarity or phase, drive chip select, or count transfer length.

The serial clock half-period is the programmed prescale plus one source cycle. This gives a serial clock rate of the source rate divided by 2 × (prescale + 1). The gap between words is 4 × code + 10 source cycles, with the code limited to the range 1 to 30. The shift engine reports the last clock edge of a word with a word-done pulse and says through a level input whether another word follows.

Top module: `spi_sck_gap_timer`

## Requirements
- R1: After a word-start strobe in cycle w, with prescale P latched, toggle strobes appear in cycles w+P, w+P+(P+1), w+P+2(P+1) and so on, one cycle wide each.
- R2: A prescale of 0 gives a toggle strobe in every running cycle, the first one in the same cycle as the word-start strobe.
- R3: For a gap code c in 1..30, the gap lasts 4c+10 source cycles whatever the prescale.
- R4: A gap code of 0 is treated as 1 (14 cycles), and a code of 31 is treated as 30 (130 cycles).
- R5: A word-done pulse seen in a running cycle d makes gap_active_o high from cycle d+1, for exactly the gap length. The gap code is taken at that same edge.
- R6: A start request in idle gives a one-cycle word_start_o in the next cycle. If more_i is high in the last gap cycle, word_start_o pulses in the cycle right after the gap.
- R7: The prescale is taken only when a word starts. Changing it in the middle of a word does not alter that word's toggle spacing.
- R8: No toggle strobes are issued during a gap or while idle. sck_o is 0 during every gap and while idle.
- R9: A start request while running or in a gap has no effect: no extra word_start_o and no change in timing.
- R10: If more_i is low in the last gap cycle, the block returns to idle, and busy_o falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prescale_i | input | 16 | Serial clock half-period minus one, in source cycles |
| gap_code_i | input | 5 | Inter-word gap code |
| start_i | input | 1 | Start request; acted on only when idle |
| word_done_i | input | 1 | Last serial clock edge of the current word |
| more_i | input | 1 | Another word follows the current gap |
| sck_toggle_o | output | 1 | Strobe: toggle the serial clock in this cycle |
| sck_o | output | 1 | Serial clock level before polarity; 0 at rest |
| word_start_o | output | 1 | Strobe in the first cycle of a word |
| gap_active_o | output | 1 | High during the inter-word gap |
| busy_o | output | 1 | High while a word or a gap is in progress |

## Verification
Two pairs of events can fall in the same cycle.

- **Word-done and final toggle.** The bench raises word_done_i in exactly the cycle of the final toggle strobe of each word. It then expects the gap to begin on the next cycle, with no further strobe.
- **Gap end and word start.** The last gap cycle is followed at once by the next word-start strobe. With a prescale of 0, that same cycle also carries the first toggle.

A scoreboard of expected (event, cycle) pairs judges all of these. Any event that arrives at the wrong cycle, is missing, or is not expected at all is reported.

// File: rtl/spi_sck_gap_timer.sv
module spi_sck_gap_timer #(
  parameter int PRESC_W      = 16,
  parameter int GAP_W        = 5,
  parameter int GAP_MIN_CODE = 1,
  parameter int GAP_MAX_CODE = 30,
  parameter int GAP_STEP     = 4,
  parameter int GAP_BASE     = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] prescale_i,
  input  logic [GAP_W-1:0]   gap_code_i,
  input  logic               start_i,
  input  logic               word_done_i,
  input  logic               more_i,
  output logic               sck_toggle_o,
  output logic               sck_o,
  output logic               word_start_o,
  output logic               gap_active_o,
  output logic               busy_o
);
  localparam int GAP_MAX_LEN = GAP_STEP * GAP_MAX_CODE + GAP_BASE;
  localparam int GAP_MIN_LEN = GAP_STEP * GAP_MIN_CODE + GAP_BASE;
  localparam int LEN_W       = $clog2(GAP_MAX_LEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} state_t;

  state_t             st_q;
  logic [PRESC_W-1:0] div_q, cnt_q;
  logic [LEN_W-1:0]   gap_len_q, gap_cnt_q;
  logic               sck_q, ws_q;
  logic [GAP_W-1:0]   code_c;
  logic [LEN_W-1:0]   gap_len_c;

  assign code_c = (int'(gap_code_i) < GAP_MIN_CODE) ? GAP_W'(GAP_MIN_CODE) :
                  (int'(gap_code_i) > GAP_MAX_CODE) ? GAP_W'(GAP_MAX_CODE) : gap_code_i;
  assign gap_len_c = LEN_W'(code_c) * LEN_W'(GAP_STEP) + LEN_W'(GAP_BASE);

  assign sck_toggle_o = (st_q == S_RUN) && (cnt_q == div_q);
  assign sck_o        = sck_q;
  assign word_start_o = ws_q;
  assign gap_active_o = (st_q == S_GAP);
  assign busy_o       = (st_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      div_q     <= '0;
      cnt_q     <= '0;
      gap_len_q <= '0;
      gap_cnt_q <= '0;
      sck_q     <= 1'b0;
      ws_q      <= 1'b0;
    end else begin
      ws_q <= 1'b0;
      case (st_q)
        S_IDLE: if (start_i) begin
          st_q  <= S_RUN;
          div_q <= prescale_i;
          cnt_q <= '0;
          ws_q  <= 1'b1;
        end
        S_RUN: begin
          if (word_done_i) begin
            st_q      <= S_GAP;
            gap_len_q <= gap_len_c;
            gap_cnt_q <= '0;
            cnt_q     <= '0;
            sck_q     <= 1'b0;
          end else if (sck_toggle_o) begin
            cnt_q <= '0;
            sck_q <= ~sck_q;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_GAP: begin
          if (gap_cnt_q == gap_len_q - LEN_W'(1)) begin
            if (more_i) begin
              st_q  <= S_RUN;
              div_q <= prescale_i;
              cnt_q <= '0;
              ws_q  <= 1'b1;
            end else begin
              st_q <= S_IDLE;
            end
          end else begin
            gap_cnt_q <= gap_cnt_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o || gap_active_o) |-> !sck_o) else $error("sck high at rest"); // R8

  AST_NO_TOGGLE_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_active_o || !busy_o) |-> !sck_toggle_o) else $error("toggle outside word"); // R8

  AST_WS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_start_o |=> !word_start_o) else $error("word start longer than one cycle"); // R6

  AST_PRESCALE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !gap_active_o && !word_start_o) |-> $stable(div_q)) else $error("prescale changed mid-word"); // R7

  AST_GAP_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    gap_active_o |-> (int'(gap_len_q) >= GAP_MIN_LEN && int'(gap_len_q) <= GAP_MAX_LEN)) else $error("gap length out of range"); // R4

  AST_GAP_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    gap_active_o |-> (gap_cnt_q < gap_len_q)) else $error("gap counter overrun"); // R3

  AST_GAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !gap_active_o && word_done_i) |=> gap_active_o) else $error("gap did not follow word done"); // R5
endmodule

// File: tb/spi_sck_gap_timer_bench.sv
module spi_sck_gap_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] prescale_i = '0;
  logic [4:0]  gap_code_i = '0;
  logic start_i = 1'b0, word_done_i = 1'b0, more_i = 1'b0;
  logic sck_toggle_o, sck_o, word_start_o, gap_active_o, busy_o;

  int checks = 0, errors = 0, cyc = 0;
  int exp_kind[$], exp_cyc[$], exp_req[$];
  logic prev_gap = 1'b0;
  bit done = 1'b0;

  localparam int EV_TOG = 0, EV_WS = 1, EV_RISE = 2, EV_FALL = 3;

  always #2 clk = ~clk;

  spi_sck_gap_timer u_spi_sck_gap_timer (
    .clk(clk), .rst_n(rst_n), .prescale_i(prescale_i), .gap_code_i(gap_code_i),
    .start_i(start_i), .word_done_i(word_done_i), .more_i(more_i),
    .sck_toggle_o(sck_toggle_o), .sck_o(sck_o), .word_start_o(word_start_o),
    .gap_active_o(gap_active_o), .busy_o(busy_o));

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int gap_len(input int code);
    int c;
    c = (code < 1) ? 1 : (code > 30) ? 30 : code;
    return 4 * c + 10;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic push(input int kind, input int c, input int req);
    exp_kind.push_back(kind); exp_cyc.push_back(c); exp_req.push_back(req);
  endtask

  task automatic observe(input int kind);
    int k, c, r;
    if (exp_kind.size() == 0) begin
      check(1'b0, "R9 unexpected event", kind, -1);
    end else begin
      k = exp_kind.pop_front(); c = exp_cyc.pop_front(); r = exp_req.pop_front();
      check(k == kind, $sformatf("R%0d event kind", r), kind, k);
      check(c == cyc, $sformatf("R%0d event cycle", r), cyc, c);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_gap && !gap_active_o) observe(EV_FALL);
      if (!prev_gap && gap_active_o) begin
        observe(EV_RISE);
        check(sck_o == 1'b0, "R8 sck level in gap", sck_o, 0);
      end
      if (word_start_o) observe(EV_WS);
      if (sck_toggle_o) observe(EV_TOG);
      prev_gap = gap_active_o;
    end
  end

  task automatic start_xfer(input int p, output int w);
    prescale_i = 16'(p);
    start_i = 1'b1;
    push(EV_WS, cyc + 1, 6);
    @(negedge clk);
    start_i = 1'b0;
    w = cyc;
  endtask

  task automatic do_word(input int p, input int n, input int code, input bit more,
                         input int next_p, input int req, output int next_w, input int w);
    int t_last, l;
    for (int k = 0; k < n; k++) push(EV_TOG, w + p + k * (p + 1), req);
    t_last = w + p + (n - 1) * (p + 1);
    l = gap_len(code);
    push(EV_RISE, t_last + 1, 5);
    push(EV_FALL, t_last + l + 1, 3);
    if (more) push(EV_WS, t_last + l + 1, 6);
    while (cyc < w) @(negedge clk);
    prescale_i = 16'(next_p);
    gap_code_i = 5'(code);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (cyc < t_last) @(negedge clk);
    word_done_i = 1'b1;
    more_i = more;
    @(negedge clk);
    word_done_i = 1'b0;
    next_w = t_last + l + 1;
  endtask

  initial begin
    int w, nw;
    repeat (3) @(negedge clk);
    check(sck_toggle_o == 0 && word_start_o == 0 && gap_active_o == 0 && busy_o == 0 && sck_o == 0,
          "R8 reset state", {sck_toggle_o, word_start_o, gap_active_o, busy_o, sck_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy_o == 0 && sck_toggle_o == 0, "R8 idle after reset", busy_o, 0);

    start_xfer(3, w);
    do_word(3, 8, 5, 1'b1, 0, 1, nw, w);   // R1 spacing, R3 code 5, R7 change mid-word
    do_word(0, 8, 0, 1'b1, 7, 2, w, nw);   // R2 half rate, R4 code 0
    do_word(7, 4, 31, 1'b1, 1, 7, nw, w);  // R7 new prescale, R4 code 31
    do_word(1, 6, 1, 1'b0, 2, 1, w, nw);   // R10 end of transfer
    while (cyc < w) @(negedge clk);
    @(negedge clk);
    check(busy_o == 0, "R10 idle after last gap", busy_o, 0);
    repeat (30) @(negedge clk);
    check(sck_o == 0 && busy_o == 0, "R8 rest while idle", sck_o, 0);

    start_xfer(2, w);
    do_word(2, 4, 30, 1'b0, 5, 3, nw, w);  // R3 code 30
    while (cyc <= nw) @(negedge clk);
    repeat (10) @(negedge clk);
    check(exp_kind.size() == 0, "R6 all expected events seen", exp_kind.size(), 0);
    check(busy_o == 0 && sck_o == 0, "R10 final idle", busy_o, 0);
    done = 1'b1;
  end

  initial begin
    int limit;
    limit = 100000;
    while (!done && limit > 0) begin @(negedge clk); limit--; end
    if (!done) check(1'b0, "R6 watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule